// File: doc/BRIEF.md
# Multi-Mode Response Compactor

This block sits at the output of a circuit under test during self-test and reduces a serial response stream to one 8-bit word. Each cycle in which `respValid` is high, the response bit `respBit` is folded into a shared accumulator. The `mode` input picks how the bit is folded in:

- by counting changes of level between consecutive bits,
- by counting the bits that are 1, or
- by shifting the bit into a linear-feedback signature register.

Each method has its own chance of mapping a faulty stream onto the good word.

The test sequencer selects the mode and pulses `clear` before a run. It then streams the responses, for example the eight responses of an exhaustive test of a 2:1 multiplexer. After the last strobe it compares the compacted word on `result` against a known-good value on `expected`, and `pass` reports the outcome. Stimulus generation and test sequencing lie outside this block.

Top module: `rc_compactor`

## Requirements
- R1: After reset `result` is 0 and `pass` is 0.
- R2: A cycle with `clear` high sets the accumulator to 0 and forgets any previous bit. `clear` takes priority over a simultaneous `respValid`, and that strobe is dropped.
- R3: In transition mode (`mode` = 2'b00), the first valid bit after reset or clear only records that bit and never changes `result`.
- R4: In transition mode, each later valid bit that differs from the previous valid bit adds one to `result`. A valid bit equal to the previous one leaves `result` unchanged.
- R5: In ones mode (`mode` = 2'b01), each valid bit equal to 1 adds one to `result`. A valid 0 leaves `result` unchanged.
- R6: In signature mode (`mode` = 2'b10), each valid bit b turns state s into {s[6:0], b ^ s[7] ^ s[5] ^ s[4] ^ s[3]}.
- R7: The counting modes saturate. Once `result` is 255, further increments leave it at 255.
- R8: Mode 2'b11 is reserved. While it is selected, `result` reads 0 and `pass` is 0, and strobes leave the accumulator untouched. Returning to the earlier mode shows the earlier value.
- R9: `pass` is 1 exactly when at least one strobe has been accepted in a non-reserved mode since reset or clear, the mode is not reserved, and `result` equals `expected`.
- R10: In a cycle without `respValid` or `clear`, the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of the accumulator and history |
| mode | input | 2 | Compaction method: 00 transitions, 01 ones, 10 signature, 11 reserved |
| respValid | input | 1 | Strobe marking `respBit` as a response bit |
| respBit | input | 1 | Serial response from the circuit under test |
| expected | input | 8 | Known-good compacted value |
| result | output | 8 | Compacted value |
| pass | output | 1 | Match of `result` against `expected` after a run |

## Verification
The eight responses of an exhaustive 2:1 multiplexer test are compacted in all three modes. This gives a transition count of 5, a ones count of 4 and a distinct signature, and shows that the modes differ on the same stream. Random streams of random length, with gaps in the strobe, are compared step by step with a bench model. These tell apart a wrong first-bit rule, a wrong feedback tap and a lost hold. Long streams of ones and of alternating bits drive the counters into saturation. Directed cases cover clear colliding with a strobe, strobes under the reserved mode, and `pass` against matching and mismatching expected words.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;

  typedef enum logic [1:0] {
    MODE_TRANS = 2'b00,
    MODE_ONES  = 2'b01,
    MODE_SIG   = 2'b10,
    MODE_RSV   = 2'b11
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;      // zero accumulator and previous bit
    logic capture;  // record the current bit as previous
    logic inc;      // saturating increment
    logic shift;    // signature shift
  } ctrl_t;

endpackage

// File: rtl/rc_ctrl.sv
`timescale 1ns/1ps
module rc_ctrl
  import rc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic [1:0] mode,
  input  logic       respValid,
  input  logic       respBit,
  input  logic       prevBit,
  output ctrl_t      ctl,
  output logic       armed
);

  mode_e modeSel;
  logic  havePrev;
  logic  accept;

  assign modeSel = mode_e'(mode);
  assign accept  = respValid && !clear;

  always_comb begin
    ctl = '0;
    ctl.clr = clear;
    if (accept) begin
      unique case (modeSel)
        MODE_TRANS: begin
          ctl.capture = 1'b1;
          ctl.inc     = havePrev && (respBit != prevBit);
        end
        MODE_ONES:  ctl.inc   = respBit;
        MODE_SIG:   ctl.shift = 1'b1;
        default:    ctl = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      havePrev <= 1'b0;
      armed    <= 1'b0;
    end else if (clear) begin
      havePrev <= 1'b0;
      armed    <= 1'b0;
    end else if (accept && modeSel != MODE_RSV) begin
      armed <= 1'b1;
      if (modeSel == MODE_TRANS) havePrev <= 1'b1;
    end
  end

endmodule

// File: rtl/rc_datapath.sv
`timescale 1ns/1ps
module rc_datapath
  import rc_pkg::*;
#(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'b1011_1000
)(
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_t        ctl,
  input  logic [1:0]   mode,
  input  logic         respBit,
  input  logic         armed,
  input  logic [W-1:0] expected,
  output logic         prevBit,
  output logic [W-1:0] result,
  output logic         pass
);

  localparam logic [W-1:0] SAT_MAX = {W{1'b1}};

  logic [W-1:0] acc;
  logic [W-1:0] accNext;
  logic         feedback;
  logic         reserved;

  assign feedback = respBit ^ (^(acc & POLY));
  assign reserved = (mode_e'(mode) == MODE_RSV);

  always_comb begin
    accNext = acc;
    if (ctl.clr)                        accNext = '0;
    else if (ctl.shift)                 accNext = {acc[W-2:0], feedback};
    else if (ctl.inc && acc != SAT_MAX) accNext = acc + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      prevBit <= 1'b0;
    end else begin
      acc <= accNext;
      if (ctl.clr)          prevBit <= 1'b0;
      else if (ctl.capture) prevBit <= respBit;
    end
  end

  assign result = reserved ? '0 : acc;
  assign pass   = armed && !reserved && (acc == expected);

endmodule

// File: rtl/rc_compactor.sv
`timescale 1ns/1ps
module rc_compactor
  import rc_pkg::*;
#(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'b1011_1000
)(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic [1:0]   mode,
  input  logic         respValid,
  input  logic         respBit,
  input  logic [W-1:0] expected,
  output logic [W-1:0] result,
  output logic         pass
);

  ctrl_t ctl;
  logic  armed;
  logic  prevBit;

  rc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .clear(clear), .mode(mode),
    .respValid(respValid), .respBit(respBit), .prevBit(prevBit),
    .ctl(ctl), .armed(armed)
  );

  rc_datapath #(.W(W), .POLY(POLY)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mode(mode), .respBit(respBit),
    .armed(armed), .expected(expected), .prevBit(prevBit),
    .result(result), .pass(pass)
  );

endmodule

// File: rtl/rc_compactor_chk.sv
`timescale 1ns/1ps
module rc_compactor_chk #(
  parameter int W = 8
)(
  input logic         clk,
  input logic         rstN,
  input logic         clear,
  input logic [1:0]   mode,
  input logic         respValid,
  input logic         respBit,
  input logic [W-1:0] expected,
  input logic [W-1:0] result,
  input logic         pass
);

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (result == '0));

  a_r5_zero_no_count: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && respValid && !respBit && !clear) |=>
      (mode != 2'b01 || result == $past(result)));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && result == {W{1'b1}} && !clear) |=>
      (mode != 2'b01 || result == {W{1'b1}}));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11) |-> (result == '0 && !pass));

  a_r9_pass_match: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> (result == expected));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!respValid && !clear) |=> (mode != $past(mode) || result == $past(result)));

endmodule

bind rc_compactor rc_compactor_chk #(.W(W)) uChk (
  .clk(clk), .rstN(rstN), .clear(clear), .mode(mode),
  .respValid(respValid), .respBit(respBit), .expected(expected),
  .result(result), .pass(pass)
);

// File: tb/rc_compactor_test.sv
`timescale 1ns/1ps
module rc_compactor_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clear = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       respValid = 1'b0;
  logic       respBit = 1'b0;
  logic [7:0] expected = 8'h00;
  logic [7:0] result;
  logic       pass;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench model state
  logic [7:0] mAcc = 8'h00;
  logic       mPrev = 1'b0;
  logic       mHave = 1'b0;
  logic       mSaw = 1'b0;

  always #2 clk = ~clk;

  rc_compactor uut (
    .clk(clk), .rstN(rstN), .clear(clear), .mode(mode),
    .respValid(respValid), .respBit(respBit), .expected(expected),
    .result(result), .pass(pass)
  );

  function automatic logic [7:0] sigNext(input logic [7:0] s, input logic b);
    return {s[6:0], b ^ s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [7:0] satInc(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  function automatic logic [7:0] modelResult(input logic [1:0] m, input logic [7:0] a);
    return (m == 2'b11) ? 8'h00 : a;
  endfunction

  function automatic logic modelPass(input logic [1:0] m, input logic [7:0] a,
                                     input logic s, input logic [7:0] e);
    return s && (m != 2'b11) && (a == e);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep(input logic v, input logic b, input logic c);
    if (c) begin
      mAcc = 8'h00; mPrev = 1'b0; mHave = 1'b0; mSaw = 1'b0;
    end else if (v) begin
      case (mode)
        2'b00: begin
          if (mHave && b != mPrev) mAcc = satInc(mAcc);
          mPrev = b; mHave = 1'b1; mSaw = 1'b1;
        end
        2'b01: begin
          if (b) mAcc = satInc(mAcc);
          mSaw = 1'b1;
        end
        2'b10: begin
          mAcc = sigNext(mAcc, b);
          mSaw = 1'b1;
        end
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic v, input logic b, input logic c);
    respValid = v; respBit = b; clear = c;
    @(posedge clk); #1;
    modelStep(v, b, c);
    respValid = 1'b0; clear = 1'b0;
  endtask

  task automatic checkResult(input string req);
    check(req, {24'd0, result}, {24'd0, modelResult(mode, mAcc)});
  endtask

  // mux output for exhaustive vector i: a=i[0], b=i[1], s=i[2]
  function automatic logic muxOut(input int i);
    return i[2] ? i[1] : i[0];
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [7:0] keep;
    seed = $urandom(32'd4177);

    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 result", {24'd0, result}, 32'd0);
    check("R1 pass", {31'd0, pass}, 32'd0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R3/R4: transitions on multiplexer stream, expect 5
    mode = 2'b00;
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    check("R3 first bit uncounted", {24'd0, result}, 32'd0);
    step(1'b1, 1'b0, 1'b0);
    check("R4 first change", {24'd0, result}, 32'd1);
    step(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) step(1'b1, muxOut(i), 1'b0);
    check("R4 mux transitions", {24'd0, result}, 32'd5);
    expected = 8'd5; #1;
    check("R9 pass on match", {31'd0, pass}, 32'd1);
    expected = 8'd4; #1;
    check("R9 fail on mismatch", {31'd0, pass}, 32'd0);

    // R5: ones count, expect 4
    mode = 2'b01;
    step(1'b0, 1'b0, 1'b1);
    expected = 8'd0; #1;
    check("R9 no pass before strobe", {31'd0, pass}, 32'd0);
    for (int i = 0; i < 8; i++) step(1'b1, muxOut(i), 1'b0);
    check("R5 mux ones", {24'd0, result}, 32'd4);

    // R6: signature of mux stream
    mode = 2'b10;
    step(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) step(1'b1, muxOut(i), 1'b0);
    checkResult("R6 mux signature");
    expected = mAcc; #1;
    check("R9 signature pass", {31'd0, pass}, 32'd1);

    // R2: clear beats strobe
    step(1'b1, 1'b1, 1'b1);
    check("R2 clear with strobe", {24'd0, result}, 32'd0);
    check("R2 pass after clear", {31'd0, pass}, 32'd0);

    // R7: saturation in both counting modes
    mode = 2'b01;
    step(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b0);
    check("R7 ones saturate", {24'd0, result}, 32'd255);
    mode = 2'b00;
    step(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 300; i++) step(1'b1, i[0], 1'b0);
    check("R7 transitions saturate", {24'd0, result}, 32'd255);

    // R8: reserved mode
    mode = 2'b01;
    step(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b0);
    keep = result;
    expected = 8'd0;
    mode = 2'b11; #1;
    check("R8 reserved result", {24'd0, result}, 32'd0);
    check("R8 reserved pass", {31'd0, pass}, 32'd0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0);
    mode = 2'b01; #1;
    check("R8 state untouched", {24'd0, result}, {24'd0, keep});

    // R10: idle cycles hold
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0);
    check("R10 idle hold", {24'd0, result}, {24'd0, keep});

    // random runs against model (R3 R4 R5 R6 R9 R10)
    for (int run = 0; run < 300; run++) begin
      int len;
      mode = 2'($urandom_range(0, 2));
      len = $urandom_range(1, 40);
      step(1'b0, 1'b0, 1'b1);
      for (int k = 0; k < len; k++) begin
        step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), 1'b0);
        checkResult("R4 R5 R6 R10 random step");
      end
      expected = ($urandom_range(0, 1) != 0) ? mAcc : 8'($urandom_range(0, 255));
      #1;
      check("R9 random pass", {31'd0, pass}, {31'd0, modelPass(mode, mAcc, mSaw, expected)});
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule